// File: doc/BRIEF.md
# Ethernet MAC interrupt event and mask bank

This block collects the interrupt events of an Ethernet MAC into one 32-bit event register and drives thirteen separate level interrupt lines from it. The other parts of the MAC set events with one-cycle set pulses. Software clears events by writing ones to the event register, and it selects which events reach their lines through a 32-bit mask register.

The block also holds a small control register that contains an enable bit and a self-clearing soft reset. It keeps a receive-active flag that follows the enable bit. A write to the transmit control select with a graceful-stop request raises the graceful-stop-complete event in the same cycle, because stopping needs no further work.

The register port is plain: one write strobe, a select and a data word. There is no data stream, so there is no valid/ready handshake and no back-pressure. The event register, mask register, control bits and receive-active flag are visible at all times on output pins.

Top module: `irqbank_top`

## Requirements
- R1: Only event bits 31 down to 19 are stored. A set pulse on one of these bits makes it read 1 after the next clock edge. Bits 18 to 0 always read 0, and set pulses on them have no effect. Bit meanings are: 31 heartbeat, 30 babbling receive, 29 babbling transmit, 28 graceful stop complete, 27 TX frame, 26 TX buffer, 25 RX frame, 24 RX buffer, 23 MII, 22 bus error, 21 late collision, 20 retry limit, 19 underrun.
- R2: A write with `wr_sel`=0 clears every event bit that is 1 in `wr_data`. Bits written as 0 keep their value.
- R3: If a set pulse and a write-one-to-clear reach the same event bit in the same cycle, the bit ends up 1.
- R4: Line i is driven from event bit b(i), where b = 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30 for i = 0..12. Each line is high exactly when event bit b(i) and mask bit b(i) were both 1 one cycle earlier. The lines are registered.
- R5: A write with `wr_sel`=1 loads all 32 bits of the mask register.
- R6: A write with `wr_sel`=2 loads control bit 1 (enable) and bit 0. If `wr_data` bit 0 is 1, the write is a soft reset instead: it clears the event register, the mask register, both control bits and the receive-active flag. In that cycle the soft reset takes priority over set pulses.
- R7: A write with `wr_sel`=3 and `wr_data` bit 0 set raises event bit 28 after that clock edge.
- R8: An `rx_start` pulse sets the receive-active flag only while the stored enable bit is 1. A control write with bit 1 = 0 clears the flag, and that clear wins over `rx_start` in the same cycle.
- R9: After `rst_n` is asserted, the event register, mask register, control bits, receive-active flag and all lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_set | input | 32 | One-cycle event set pulses, one per event bit |
| rx_start | input | 1 | Request to mark the receiver active |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 event, 1 mask, 2 control, 3 transmit control |
| wr_data | input | 32 | Write data |
| evt_q | output | 32 | Event register |
| mask_q | output | 32 | Mask register |
| ctrl_q | output | 2 | Control bits: [1] enable, [0] reads 0 after a reset write |
| rx_active | output | 1 | Receive-active flag |
| irq | output | 13 | Level interrupt lines |

## Verification
Event, mask, control and receive-active results appear one clock edge after the stimulus that causes them. The interrupt lines trail the event and mask registers by one further edge, so they appear two edges after the original set pulse or write. The bench drives its inputs just after a falling edge and advances its reference model once per rising edge. The model computes the new lines from the register values that held before that edge. Every output is compared at the following falling edge, so each check sees exactly one edge of delay per register stage.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;
  localparam int EVW   = 32;
  localparam int NLINE = 13;
  localparam int EVLO  = 19;
  localparam int B_GRA = 28;
  localparam int C_EN  = 1;
  localparam int C_RST = 0;

  typedef enum logic [1:0] {
    SEL_EVT  = 2'd0,
    SEL_MASK = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_TXC  = 2'd3
  } sel_e;

  // event bit feeding each interrupt line
  function automatic int unsigned line_bit(input int unsigned idx);
    case (idx)
      0: line_bit = 27;  1: line_bit = 26;  2: line_bit = 19;
      3: line_bit = 20;  4: line_bit = 25;  5: line_bit = 24;
      6: line_bit = 23;  7: line_bit = 21;  8: line_bit = 31;
      9: line_bit = 28;  10: line_bit = 22; 11: line_bit = 29;
      default: line_bit = 30;
    endcase
  endfunction
endpackage

// File: rtl/irqbank_ctrl.sv
module irqbank_ctrl
  import irqbank_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [1:0] wr_lo,
  input  logic       rx_start,
  output logic [1:0] ctrl_q,
  output logic       rx_active,
  output logic       soft_rst,
  output logic       gra_hit
);
  logic ctrl_wr;

  assign ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
  assign soft_rst = ctrl_wr && wr_lo[C_RST];
  assign gra_hit  = wr_en && (wr_sel == SEL_TXC) && wr_lo[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      rx_active <= 1'b0;
    end else begin
      if (soft_rst)     ctrl_q <= '0;
      else if (ctrl_wr) ctrl_q <= wr_lo;
      if (soft_rst || (ctrl_wr && !wr_lo[C_EN])) rx_active <= 1'b0;
      else if (rx_start && ctrl_q[C_EN])          rx_active <= 1'b1;
    end
  end

  assert_rxoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[C_EN] |-> !rx_active);
  assert_ctrlrst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ctrl_q == 2'b00 && !rx_active));
endmodule

// File: rtl/irqbank_events.sv
module irqbank_events
  import irqbank_pkg::*;
#(
  parameter int W  = EVW,
  parameter int LO = EVLO
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_in,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         soft_rst,
  input  logic         gra_hit,
  output logic [W-1:0] evt_q,
  output logic [W-1:0] mask_q
);
  localparam logic [W-1:0] IMPL = {{(W-LO){1'b1}}, {LO{1'b0}}};

  logic [W-1:0] clr_vec, gra_vec, evt_nxt;

  assign clr_vec = (wr_en && wr_sel == SEL_EVT) ? wr_data : '0;
  assign gra_vec = gra_hit ? (W'(1) << B_GRA) : '0;
  assign evt_nxt = ((evt_q & ~clr_vec) | set_in | gra_vec) & IMPL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      mask_q <= '0;
    end else if (soft_rst) begin
      evt_q  <= '0;
      mask_q <= '0;
    end else begin
      evt_q <= evt_nxt;
      if (wr_en && wr_sel == SEL_MASK) mask_q <= wr_data;
    end
  end

  assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_EVT) |=> ((evt_q & $past(wr_data & ~set_in)) == '0));
  assert_setwins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && |(set_in & IMPL)) |=> ((evt_q & $past(set_in & IMPL)) == $past(set_in & IMPL)));
  assert_evtrst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (evt_q == '0 && mask_q == '0));
  assert_gra_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gra_hit && !soft_rst) |=> evt_q[B_GRA]);
endmodule

// File: rtl/irqbank_lines.sv
module irqbank_lines
  import irqbank_pkg::*;
#(
  parameter int W = EVW,
  parameter int N = NLINE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_q,
  input  logic [W-1:0] mask_q,
  output logic [N-1:0] irq
);
  for (genvar i = 0; i < N; i++) begin : g_line
    localparam int unsigned B = line_bit(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq[i] <= 1'b0;
      else        irq[i] <= evt_q[B] & mask_q[B];
    end
    assert_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq[i] == $past(evt_q[B] & mask_q[B])));
  end
endmodule

// File: rtl/irqbank_top.sv
module irqbank_top
  import irqbank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] evt_set,
  input  logic        rx_start,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] evt_q,
  output logic [31:0] mask_q,
  output logic [1:0]  ctrl_q,
  output logic        rx_active,
  output logic [12:0] irq
);
  logic soft_rst, gra_hit;

  irqbank_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_lo(wr_data[1:0]), .rx_start(rx_start), .ctrl_q(ctrl_q),
    .rx_active(rx_active), .soft_rst(soft_rst), .gra_hit(gra_hit)
  );

  irqbank_events #(.W(EVW), .LO(EVLO)) u_evt (
    .clk(clk), .rst_n(rst_n), .set_in(evt_set), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .soft_rst(soft_rst),
    .gra_hit(gra_hit), .evt_q(evt_q), .mask_q(mask_q)
  );

  irqbank_lines #(.W(EVW), .N(NLINE)) u_lines (
    .clk(clk), .rst_n(rst_n), .evt_q(evt_q), .mask_q(mask_q), .irq(irq)
  );
endmodule

// File: tb/sim_irqbank_top.sv
module sim_irqbank_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt_set = '0;
  logic        rx_start = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] evt_q, mask_q;
  logic [1:0]  ctrl_q;
  logic        rx_active;
  logic [12:0] irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] IMPL = 32'hFFF8_0000;
  int lb[13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};

  logic [31:0] m_evt = '0, m_mask = '0;
  logic [1:0]  m_ctrl = '0;
  logic        m_rx = 1'b0;
  logic [12:0] m_irq = '0;

  always #2 clk = ~clk;

  irqbank_top u0 (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .rx_start(rx_start),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .evt_q(evt_q),
    .mask_q(mask_q), .ctrl_q(ctrl_q), .rx_active(rx_active), .irq(irq)
  );

  function automatic logic [12:0] lines_of(input logic [31:0] e, input logic [31:0] m);
    logic [12:0] r;
    for (int i = 0; i < 13; i++) r[i] = e[lb[i]] & m[lb[i]];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [31:0] clr;
    m_irq = lines_of(m_evt, m_mask);
    if (wr_en && wr_sel == 2 && wr_data[0]) begin
      m_evt = '0; m_mask = '0; m_ctrl = '0; m_rx = 1'b0;
    end else begin
      clr = (wr_en && wr_sel == 0) ? wr_data : '0;
      m_evt = ((m_evt & ~clr) | evt_set |
               ((wr_en && wr_sel == 3 && wr_data[0]) ? 32'h1000_0000 : '0)) & IMPL;
      if (wr_en && wr_sel == 1) m_mask = wr_data;
      if (wr_en && wr_sel == 2 && !wr_data[1]) m_rx = 1'b0;
      else if (rx_start && m_ctrl[1]) m_rx = 1'b1;
      if (wr_en && wr_sel == 2) m_ctrl = wr_data[1:0];
    end
  endtask

  task automatic compare_all();
    chk("R2 event", evt_q, m_evt);
    chk("R5 mask", mask_q, m_mask);
    chk("R6 control", {30'd0, ctrl_q}, {30'd0, m_ctrl});
    chk("R8 rx flag", {31'd0, rx_active}, {31'd0, m_rx});
    chk("R4 lines", {19'd0, irq}, {19'd0, m_irq});
  endtask

  task automatic cyc(input logic we, input logic [1:0] sel, input logic [31:0] d,
                     input logic [31:0] sv, input logic rs);
    wr_en = we; wr_sel = sel; wr_data = d; evt_set = sv; rx_start = rs;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    wr_en = 1'b0; evt_set = '0; rx_start = 1'b0;
    compare_all();
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R9 reset evt", evt_q, '0);
    chk("R9 reset irq", {19'd0, irq}, '0);
    chk("R9 reset rx", {31'd0, rx_active}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: low bits ignored
    cyc(1'b0, 2'd0, '0, 32'h0007_FFFF, 1'b0);
    chk("R1 low bits", evt_q, 32'h0);
    // R1/R4: set TX frame, enable mask, line 0 follows
    cyc(1'b1, 2'd1, 32'hFFFF_FFFF, 32'h0800_0000, 1'b0);
    chk("R1 set bit27", evt_q, 32'h0800_0000);
    cyc(1'b0, 2'd0, '0, '0, 1'b0);
    chk("R4 line0", {19'd0, irq}, 32'h1);
    // R3: set and clear same bit
    cyc(1'b1, 2'd0, 32'h0800_0000, 32'h0800_0000, 1'b0);
    chk("R3 set wins", evt_q & 32'h0800_0000, 32'h0800_0000);
    // R7: graceful stop
    cyc(1'b1, 2'd3, 32'h1, '0, 1'b0);
    chk("R7 gra", evt_q & 32'h1000_0000, 32'h1000_0000);
    // R8: rx flag needs enable
    cyc(1'b0, 2'd0, '0, '0, 1'b1);
    chk("R8 no enable", {31'd0, rx_active}, 0);
    cyc(1'b1, 2'd2, 32'h2, '0, 1'b0);
    cyc(1'b0, 2'd0, '0, '0, 1'b1);
    chk("R8 set", {31'd0, rx_active}, 1);
    cyc(1'b1, 2'd2, 32'h0, '0, 1'b1);
    chk("R8 clear", {31'd0, rx_active}, 0);
    // R6: soft reset beats set pulses
    cyc(1'b1, 2'd2, 32'h3, 32'hFFF8_0000, 1'b0);
    chk("R6 soft reset", evt_q | mask_q, 32'h0);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] s;
      logic [31:0] d, sv;
      s = 2'($urandom_range(0, 3));
      d = $urandom();
      if (s == 2 && ($urandom_range(0, 15) != 0)) d[0] = 1'b0;
      sv = ($urandom_range(0, 2) == 0) ? $urandom() : 32'h0;
      cyc($urandom_range(0, 1) == 1, s, d, sv, $urandom_range(0, 1) == 1);
    end
    done = 1'b1;
  end

  initial begin
    for (int k = 0; k < 150000 && !done; k++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule